// File: doc/BRIEF.md
# Write-Through Data Cache with Peer Snooping

This block is a small direct-mapped data cache for one core. The core and its peers share one bus. Every store the core issues goes to main memory, so memory never holds stale data. If the addressed line is already cached, the store also updates that local copy. A store that misses does not allocate a line. Once memory accepts a store, the cache places one coherence message on the bus. The message carries the word address, the data and the cache's own source number.

The cache also watches the messages from its peers. The `UPDATE_MODE` parameter picks one of two reactions when a message names a word the cache holds. In update mode (1) the cache patches its copy with the data in the message. In invalidate mode (0) the cache clears the valid bit of that line. A message for a word the cache does not hold is ignored, and so is a message carrying the cache's own source number. Each line keeps only a valid bit, a tag and the data word, so evicting a line never needs a write-back.

Addresses are word addresses. The low `IDX_W` bits select the line and the remaining bits form the tag. Memory is reached through a request/acknowledge pair. Arbitration of the shared bus is left to the surrounding system.

Top module: `wt_snoop_cache`

## Requirements
- R1: After reset, `cpu_ready` is 1 and `rsp_valid`, `bc_valid` and `mem_req` are 0. No line is valid, so the first read of any address goes to memory.
- R2: A read miss raises `mem_req` with `mem_we` = 0 for the requested address. The cycle after `mem_ack`, `rsp_valid` pulses with `mem_rdata`, and the word is now cached.
- R3: A read hit makes no memory request. `rsp_valid` rises in the cycle right after the request is accepted, carrying the cached word.
- R4: Every write raises `mem_req` with `mem_we` = 1. The address and data are held until `mem_ack`. A write that hits also updates the cached word, so a later read returns the new value without going to memory.
- R5: A write that misses changes no line, and a later read of that address goes to memory.
- R6: The cycle after a write's `mem_ack`, `bc_valid` is 1 for exactly one cycle. In that cycle `bc_addr`, `bc_data` and `bc_src` give the write address, the write data and `MY_SRC`. In the same cycle `rsp_valid` pulses, with `rsp_data` echoing the write data.
- R7: In update mode (`UPDATE_MODE` = 1), a peer message (`snp_src` ≠ `MY_SRC`) whose address is cached replaces the cached word with `snp_data`. A later read returns that word with no memory request.
- R8: In invalidate mode (`UPDATE_MODE` = 0), a peer message whose address is cached clears that line, and a later read goes to memory.
- R9: A peer message for an address that maps to a valid line but has a different tag leaves the line unchanged.
- R10: A message whose `snp_src` equals `MY_SRC` is ignored in both modes.
- R11: When a read is accepted in the same cycle that a peer message hits the same address, the message takes effect first. In update mode the read returns `snp_data` with no memory request. In invalidate mode the read is treated as a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req | input | 1 | Core request, taken when `cpu_ready` is 1 |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Cache can take a request this cycle |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | DATA_W | Read data, or the echoed write data |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory has completed the pending access |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |
| bc_valid | output | 1 | Coherence message issued after a completed write |
| bc_addr | output | ADDR_W | Address carried by the message |
| bc_data | output | DATA_W | Data carried by the message |
| bc_src | output | SRC_W | Source number of this cache |
| snp_valid | input | 1 | Message observed on the bus |
| snp_addr | input | ADDR_W | Observed message address |
| snp_data | input | DATA_W | Observed message data |
| snp_src | input | SRC_W | Observed message source number |

## Verification
A local read and a peer message can arrive at the same line in the same cycle. The bench provokes this by driving `cpu_req` for a cached word and `snp_valid` for that same word at the same clock edge. It does this once on an update-mode instance and once on an invalidate-mode instance. The update-mode case passes only if the response carries the message data and the memory-read count stays the same. The invalidate-mode case passes only if a memory read occurs and the response carries the memory word.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RD_MEM = 2'd1,
    ST_WR_MEM = 2'd2
  } wtc_state_e;
endpackage

// File: rtl/wtc_line_store.sv
module wtc_line_store #(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 32,
  parameter int IDX_W       = 3,
  parameter int SRC_W       = 2,
  parameter int MY_SRC      = 0,
  parameter int UPDATE_MODE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [DATA_W-1:0] snp_data,
  input  logic [SRC_W-1:0]  snp_src,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [DATA_W-1:0] fill_data
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  logic              vld_q   [LINES];
  logic [TAG_W-1:0]  tag_q   [LINES];
  logic [DATA_W-1:0] dat_q   [LINES];
  logic              vld_d   [LINES];
  logic [TAG_W-1:0]  tag_d   [LINES];
  logic [DATA_W-1:0] dat_d   [LINES];
  logic              eff_vld [LINES];
  logic [DATA_W-1:0] eff_dat [LINES];
  logic              sn_hit  [LINES];
  logic              fill_at [LINES];
  logic              wr_at   [LINES];
  logic              line_en [LINES];

  logic snp_take;
  assign snp_take = snp_valid && (snp_src != SRC_W'(MY_SRC));

  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_line
      // Peer message is resolved first; local actions see its result.
      assign sn_hit[g]  = snp_take && (snp_addr[IDX_W-1:0] == IDX_W'(g)) &&
                          vld_q[g] && (tag_q[g] == snp_addr[ADDR_W-1:IDX_W]);
      assign eff_vld[g] = vld_q[g] && !(sn_hit[g] && (UPDATE_MODE == 0));
      assign eff_dat[g] = (sn_hit[g] && (UPDATE_MODE != 0)) ? snp_data : dat_q[g];
      assign fill_at[g] = fill_en && (fill_addr[IDX_W-1:0] == IDX_W'(g));
      assign wr_at[g]   = wr_en && (wr_addr[IDX_W-1:0] == IDX_W'(g)) && eff_vld[g] &&
                          (tag_q[g] == wr_addr[ADDR_W-1:IDX_W]);
      assign line_en[g] = sn_hit[g] || fill_at[g] || wr_at[g];
      assign vld_d[g]   = eff_vld[g] || fill_at[g];
      assign tag_d[g]   = fill_at[g] ? fill_addr[ADDR_W-1:IDX_W] : tag_q[g];
      assign dat_d[g]   = fill_at[g] ? fill_data : (wr_at[g] ? wr_data : eff_dat[g]);

      if (UPDATE_MODE == 0) begin : g_inv_chk
        assert_inval_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
          (sn_hit[g] && !fill_at[g]) |=> !vld_q[g]);
      end
      assert_own_msg_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && (snp_src == SRC_W'(MY_SRC)) && vld_q[g] && !fill_at[g] && !wr_at[g])
        |=> (vld_q[g] && $stable(dat_q[g])));
      assert_valid_only_by_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!vld_q[g] && !fill_at[g]) |=> !vld_q[g]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) vld_q[i] <= 1'b0;
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (line_en[i]) vld_q[i] <= vld_d[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LINES; i++) begin
      if (line_en[i]) begin
        tag_q[i] <= tag_d[i];
        dat_q[i] <= dat_d[i];
      end
    end
  end

  logic [IDX_W-1:0] lk_idx;
  assign lk_idx  = lk_addr[IDX_W-1:0];
  assign lk_hit  = eff_vld[lk_idx] && (tag_q[lk_idx] == lk_addr[ADDR_W-1:IDX_W]);
  assign lk_data = eff_dat[lk_idx];
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
  import wtc_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              lk_hit,
  input  logic [DATA_W-1:0] lk_data,
  output logic              wr_en,
  output logic              fill_en,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              bc_valid
);
  wtc_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              rsp_v_q, rsp_v_d;
  logic [DATA_W-1:0] rsp_d_q, rsp_d_d;
  logic              bc_q, bc_d;
  logic              load;

  always_comb begin
    state_d = state_q;
    rsp_v_d = 1'b0;
    rsp_d_d = rsp_d_q;
    bc_d    = 1'b0;
    load    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_req) begin
          load = 1'b1;
          if (cpu_we) begin
            state_d = ST_WR_MEM;
          end else if (lk_hit) begin
            rsp_v_d = 1'b1;
            rsp_d_d = lk_data;
          end else begin
            state_d = ST_RD_MEM;
          end
        end
      end
      ST_RD_MEM: begin
        if (mem_ack) begin
          rsp_v_d = 1'b1;
          rsp_d_d = mem_rdata;
          state_d = ST_IDLE;
        end
      end
      ST_WR_MEM: begin
        if (mem_ack) begin
          rsp_v_d = 1'b1;
          rsp_d_d = data_q;
          bc_d    = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rsp_v_q <= 1'b0;
      bc_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      rsp_v_q <= rsp_v_d;
      bc_q    <= bc_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      addr_q <= cpu_addr;
      data_q <= cpu_wdata;
    end
    if (rsp_v_d) rsp_d_q <= rsp_d_d;
  end

  assign cpu_ready = (state_q == ST_IDLE);
  assign wr_en     = load && cpu_we;
  assign fill_en   = (state_q == ST_RD_MEM) && mem_ack;
  assign mem_req   = (state_q != ST_IDLE);
  assign mem_we    = (state_q == ST_WR_MEM);
  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;
  assign rsp_valid = rsp_v_q;
  assign rsp_data  = rsp_d_q;
  assign bc_valid  = bc_q;

  assert_mem_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));
  assert_bc_after_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bc_valid |-> $past(mem_req && mem_we && mem_ack));
  assert_bc_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bc_valid |=> !bc_valid);
  assert_hit_no_mem_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && cpu_req && !cpu_we && lk_hit) |=> (rsp_valid && !mem_req));
endmodule

// File: rtl/wt_snoop_cache.sv
module wt_snoop_cache #(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 32,
  parameter int IDX_W       = 3,
  parameter int SRC_W       = 2,
  parameter int MY_SRC      = 0,
  parameter int UPDATE_MODE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              bc_valid,
  output logic [ADDR_W-1:0] bc_addr,
  output logic [DATA_W-1:0] bc_data,
  output logic [SRC_W-1:0]  bc_src,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [DATA_W-1:0] snp_data,
  input  logic [SRC_W-1:0]  snp_src
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_i;
  logic              lk_hit, wr_en, fill_en;
  logic [DATA_W-1:0] lk_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  wtc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n_i),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .lk_hit(lk_hit), .lk_data(lk_data), .wr_en(wr_en), .fill_en(fill_en),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .bc_valid(bc_valid)
  );

  wtc_line_store #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .SRC_W(SRC_W),
    .MY_SRC(MY_SRC), .UPDATE_MODE(UPDATE_MODE)
  ) store_i (
    .clk(clk), .rst_n(rst_n_i),
    .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_data(snp_data), .snp_src(snp_src),
    .lk_addr(cpu_addr), .lk_hit(lk_hit), .lk_data(lk_data),
    .wr_en(wr_en), .wr_addr(cpu_addr), .wr_data(cpu_wdata),
    .fill_en(fill_en), .fill_addr(mem_addr), .fill_data(mem_rdata)
  );

  assign bc_addr = mem_addr;
  assign bc_data = mem_wdata;
  assign bc_src  = SRC_W'(MY_SRC);

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(rst_n_i) |-> (cpu_ready && !rsp_valid && !bc_valid && !mem_req));
endmodule

// File: tb/wt_snoop_cache_tb_top.sv
module wt_snoop_cache_tb_top;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int SW = 2;
  localparam int MW = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          cpu_req   [2];
  logic          cpu_we    [2];
  logic [AW-1:0] cpu_addr  [2];
  logic [DW-1:0] cpu_wdata [2];
  logic          cpu_ready [2];
  logic          rsp_valid [2];
  logic [DW-1:0] rsp_data  [2];
  logic          mem_req   [2];
  logic          mem_we    [2];
  logic [AW-1:0] mem_addr  [2];
  logic [DW-1:0] mem_wdata [2];
  logic          mem_ack   [2];
  logic [DW-1:0] mem_rdata [2];
  logic          bc_valid  [2];
  logic [AW-1:0] bc_addr   [2];
  logic [DW-1:0] bc_data   [2];
  logic [SW-1:0] bc_src    [2];
  logic          snp_valid [2];
  logic [AW-1:0] snp_addr  [2];
  logic [DW-1:0] snp_data  [2];
  logic [SW-1:0] snp_src   [2];

  wt_snoop_cache #(.UPDATE_MODE(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req[0]), .cpu_we(cpu_we[0]),
    .cpu_addr(cpu_addr[0]), .cpu_wdata(cpu_wdata[0]), .cpu_ready(cpu_ready[0]),
    .rsp_valid(rsp_valid[0]), .rsp_data(rsp_data[0]), .mem_req(mem_req[0]),
    .mem_we(mem_we[0]), .mem_addr(mem_addr[0]), .mem_wdata(mem_wdata[0]),
    .mem_ack(mem_ack[0]), .mem_rdata(mem_rdata[0]), .bc_valid(bc_valid[0]),
    .bc_addr(bc_addr[0]), .bc_data(bc_data[0]), .bc_src(bc_src[0]),
    .snp_valid(snp_valid[0]), .snp_addr(snp_addr[0]), .snp_data(snp_data[0]),
    .snp_src(snp_src[0]));

  wt_snoop_cache #(.UPDATE_MODE(0)) dut_inv_i (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req[1]), .cpu_we(cpu_we[1]),
    .cpu_addr(cpu_addr[1]), .cpu_wdata(cpu_wdata[1]), .cpu_ready(cpu_ready[1]),
    .rsp_valid(rsp_valid[1]), .rsp_data(rsp_data[1]), .mem_req(mem_req[1]),
    .mem_we(mem_we[1]), .mem_addr(mem_addr[1]), .mem_wdata(mem_wdata[1]),
    .mem_ack(mem_ack[1]), .mem_rdata(mem_rdata[1]), .bc_valid(bc_valid[1]),
    .bc_addr(bc_addr[1]), .bc_data(bc_data[1]), .bc_src(bc_src[1]),
    .snp_valid(snp_valid[1]), .snp_addr(snp_addr[1]), .snp_data(snp_data[1]),
    .snp_src(snp_src[1]));

  // Bench memory: one-cycle acknowledge, contents seeded while reset is low.
  logic [DW-1:0] mem [2][MW];
  function automatic logic [DW-1:0] seed(int a);
    return 32'h1000_0000 + 32'(a * 7);
  endfunction
  always @(posedge clk) begin
    for (int d = 0; d < 2; d++) begin
      if (!rst_n) begin
        for (int a = 0; a < MW; a++) mem[d][a] <= seed(a);
        mem_ack[d] <= 1'b0;
      end else if (mem_req[d] && !mem_ack[d]) begin
        mem_ack[d]   <= 1'b1;
        mem_rdata[d] <= mem[d][mem_addr[d]];
        if (mem_we[d]) mem[d][mem_addr[d]] <= mem_wdata[d];
      end else begin
        mem_ack[d] <= 1'b0;
      end
    end
  end

  int checks = 0;
  int fails = 0;
  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Scoreboard queues and monitor.
  logic [DW-1:0] exp_q0[$];
  logic [DW-1:0] exp_q1[$];
  string         tag_q0[$];
  string         tag_q1[$];
  int rsp_cnt [2] = '{0, 0};
  int rd_cnt  [2] = '{0, 0};
  int wr_cnt  [2] = '{0, 0};
  int bc_cnt  [2] = '{0, 0};
  logic [AW-1:0] last_bc_addr [2];
  logic [DW-1:0] last_bc_data [2];
  logic [SW-1:0] last_bc_src  [2];
  logic          prev_bc      [2] = '{1'b0, 1'b0};

  always @(negedge clk) begin
    if (rst_n) begin
      for (int d = 0; d < 2; d++) begin
        if (rsp_valid[d]) begin
          logic [DW-1:0] e;
          string t;
          if ((d == 0 && exp_q0.size() == 0) || (d == 1 && exp_q1.size() == 0)) begin
            chk(1'b0, "R2 unexpected response", rsp_data[d], '0);
          end else begin
            if (d == 0) begin e = exp_q0.pop_front(); t = tag_q0.pop_front(); end
            else        begin e = exp_q1.pop_front(); t = tag_q1.pop_front(); end
            chk(rsp_data[d] === e, t, rsp_data[d], e);
          end
          rsp_cnt[d]++;
        end
        if (mem_req[d] && mem_ack[d]) begin
          if (mem_we[d]) wr_cnt[d]++;
          else           rd_cnt[d]++;
        end
        if (bc_valid[d]) begin
          if (prev_bc[d]) chk(1'b0, "R6 message longer than one cycle", 32'd1, 32'd0);
          bc_cnt[d]++;
          last_bc_addr[d] = bc_addr[d];
          last_bc_data[d] = bc_data[d];
          last_bc_src[d]  = bc_src[d];
        end
        prev_bc[d] = bc_valid[d];
      end
    end
  end

  task automatic push(input int d, input logic [DW-1:0] e, input string t);
    if (d == 0) begin exp_q0.push_back(e); tag_q0.push_back(t); end
    else        begin exp_q1.push_back(e); tag_q1.push_back(t); end
  endtask

  task automatic peer_msg(input int d, input logic [AW-1:0] a, input logic [DW-1:0] v,
                          input logic [SW-1:0] s);
    @(negedge clk);
    snp_valid[d] = 1'b1; snp_addr[d] = a; snp_data[d] = v; snp_src[d] = s;
    @(negedge clk);
    snp_valid[d] = 1'b0;
  endtask

  // Read, optionally with a peer message in the acceptance cycle.
  task automatic do_read(input int d, input logic [AW-1:0] a, input logic [DW-1:0] e,
                         input int exp_rd, input bit hit, input bit with_snp,
                         input logic [DW-1:0] sv, input string t);
    int rd0 = rd_cnt[d];
    int r0  = rsp_cnt[d];
    @(negedge clk);
    while (!cpu_ready[d]) @(negedge clk);
    push(d, e, t);
    cpu_req[d] = 1'b1; cpu_we[d] = 1'b0; cpu_addr[d] = a;
    if (with_snp) begin
      snp_valid[d] = 1'b1; snp_addr[d] = a; snp_data[d] = sv; snp_src[d] = 2'd1;
    end
    @(negedge clk);
    cpu_req[d] = 1'b0; snp_valid[d] = 1'b0;
    if (hit) begin
      chk(rsp_valid[d] === 1'b1, {t, " R3 one-cycle hit latency"}, 32'(rsp_valid[d]), 32'd1);
      chk(mem_req[d] === 1'b0, {t, " R3 no memory request"}, 32'(mem_req[d]), 32'd0);
    end
    wait (rsp_cnt[d] != r0);
    @(negedge clk);
    chk(rd_cnt[d] - rd0 == exp_rd, {t, " memory reads"}, 32'(rd_cnt[d] - rd0), 32'(exp_rd));
  endtask

  task automatic do_write(input int d, input logic [AW-1:0] a, input logic [DW-1:0] v,
                          input string t);
    int w0 = wr_cnt[d];
    int b0 = bc_cnt[d];
    int r0 = rsp_cnt[d];
    @(negedge clk);
    while (!cpu_ready[d]) @(negedge clk);
    push(d, v, t);
    cpu_req[d] = 1'b1; cpu_we[d] = 1'b1; cpu_addr[d] = a; cpu_wdata[d] = v;
    @(negedge clk);
    cpu_req[d] = 1'b0; cpu_we[d] = 1'b0;
    wait (rsp_cnt[d] != r0);
    @(negedge clk);
    chk(wr_cnt[d] - w0 == 1, {t, " R4 one memory write"}, 32'(wr_cnt[d] - w0), 32'd1);
    chk(mem[d][a] === v, {t, " R4 memory holds write"}, mem[d][a], v);
    chk(bc_cnt[d] - b0 == 1, {t, " R6 one message"}, 32'(bc_cnt[d] - b0), 32'd1);
    chk(last_bc_addr[d] === a, {t, " R6 message address"}, 32'(last_bc_addr[d]), 32'(a));
    chk(last_bc_data[d] === v, {t, " R6 message data"}, last_bc_data[d], v);
    chk(last_bc_src[d] === 2'd0, {t, " R6 message source"}, 32'(last_bc_src[d]), 32'd0);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    for (int d = 0; d < 2; d++) begin
      cpu_req[d] = 1'b0; cpu_we[d] = 1'b0; cpu_addr[d] = '0; cpu_wdata[d] = '0;
      snp_valid[d] = 1'b0; snp_addr[d] = '0; snp_data[d] = '0; snp_src[d] = '0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      chk(cpu_ready[d] === 1'b1, "R1 ready after reset", 32'(cpu_ready[d]), 32'd1);
      chk(rsp_valid[d] === 1'b0, "R1 no response", 32'(rsp_valid[d]), 32'd0);
      chk(bc_valid[d] === 1'b0, "R1 no message", 32'(bc_valid[d]), 32'd0);
      chk(mem_req[d] === 1'b0, "R1 no memory request", 32'(mem_req[d]), 32'd0);
    end
    for (int d = 0; d < 2; d++) begin
      // R1/R2: first read misses and fills.
      do_read(d, 10'h012, seed(10'h012), 1, 0, 0, '0, "R1 R2 first read miss");
      do_read(d, 10'h012, seed(10'h012), 0, 1, 0, '0, "R3 read hit");
      // R4: write hit updates the local copy.
      do_write(d, 10'h012, 32'hAAAA_0001, "R4 write hit");
      do_read(d, 10'h012, 32'hAAAA_0001, 0, 1, 0, '0, "R4 read after write hit");
      // R5: write miss does not allocate.
      do_write(d, 10'h033, 32'h5555_0002, "R5 write miss");
      do_read(d, 10'h033, 32'h5555_0002, 1, 0, 0, '0, "R5 read after write miss");
      // R7 / R8: peer message to a held word.
      peer_msg(d, 10'h012, 32'hBEEF_0003, 2'd1);
      if (d == 0) do_read(d, 10'h012, 32'hBEEF_0003, 0, 1, 0, '0, "R7 update patches copy");
      else        do_read(d, 10'h012, 32'hAAAA_0001, 1, 0, 0, '0, "R8 invalidate drops copy");
      // R9: same index, different tag.
      do_read(d, 10'h015, seed(10'h015), 1, 0, 0, '0, "R9 fill");
      peer_msg(d, 10'h115, 32'hDEAD_0004, 2'd1);
      do_read(d, 10'h015, seed(10'h015), 0, 1, 0, '0, "R9 tag mismatch ignored");
      // R10: own message ignored.
      peer_msg(d, 10'h015, 32'hDEAD_0005, 2'd0);
      do_read(d, 10'h015, seed(10'h015), 0, 1, 0, '0, "R10 own message ignored");
      // R11: read and peer message in the same cycle.
      if (d == 0) do_read(d, 10'h015, 32'hCAFE_0006, 0, 1, 1, 32'hCAFE_0006, "R11 update first");
      else        do_read(d, 10'h015, seed(10'h015), 1, 0, 1, 32'hCAFE_0006, "R11 invalidate first");
    end
    repeat (4) @(negedge clk);
    chk(exp_q0.size() == 0 && exp_q1.size() == 0, "R2 all responses seen",
        32'(exp_q0.size() + exp_q1.size()), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule